// File: doc/BRIEF.md
# Stereo Digital Mix Attenuator

This block adds an attenuated copy of each ADC output sample to the matching DAC input sample, separately for the left and right channels. One 16-bit control word sets both channels. Each channel has a mute flag and a 6-bit attenuation code in 1.5 dB steps. The all-ones code silences the channel's contribution on its own, whatever the mute flag says.

A sample strobe marks one shared conversion period. On that strobe the block takes two ADC samples and two DAC samples, all signed 16-bit. One clock later it presents two saturated signed 16-bit sums together with an output strobe. The ADC and DAC must be driven by the same sample strobe for the mix to be meaningful.

The control word returns to its default and refuses writes while any of these holds: the chip is in reset, the chip is powered down, or conversions are globally disabled. A write changes the setting only from the next sample strobe on, so no sample is ever built from a partly updated setting.

Top module: `stereo_mix_atten`

## Requirements
- R1: While `rst_n` is sampled low, the control word becomes 0x8080. After that edge, `mix_vld` is 0 and both mixed outputs are 0.
- R2: The control word has fixed fields. Bit 15 is the left mute flag and bits 13:8 are the left attenuation code. Bit 7 is the right mute flag and bits 5:0 are the right attenuation code. A write with `cfg_we` high stores these fields, and they can be read on `cfg_rdata` from the next cycle.
- R3: Bits 14 and 6 of `cfg_rdata` are always 0, whatever value is written.
- R4: If `pwr_n` is low or `conv_off` is high at a clock edge, the control word becomes 0x8080 at that edge, and any write in that cycle is ignored.
- R5: If a channel's mute flag is 1, that channel's output equals its DAC input sample.
- R6: If a channel's attenuation code is 63 (all ones), that channel's output equals its DAC input sample, even when the mute flag is 0.
- R7: For an unmuted channel with code c below 63, the ADC contribution is floor(adc * M / 2^(15 + c/4)). M is 32768, 27554, 23170 or 19484 when c mod 4 is 0, 1, 2 or 3. The output is the DAC sample plus this contribution.
- R8: If the sum falls outside the signed 16-bit range, the output is clamped to 32767 or -32768.
- R9: The outputs and `mix_vld` update one cycle after the `smp_vld` edge. In cycles without a strobe, `mix_vld` is 0 and the outputs hold their values.
- R10: If a write happens in the same cycle as `smp_vld`, that sample still uses the old setting. The new setting applies from the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_n | input | 1 | Active-low power-down; holds control word at default |
| conv_off | input | 1 | Conversions globally disabled; holds control word at default |
| cfg_we | input | 1 | Control word write enable |
| cfg_wdata | input | 16 | Control word write data |
| cfg_rdata | output | 16 | Current control word |
| smp_vld | input | 1 | Shared sample-period strobe |
| adc_l | input | 16 | Left ADC sample, signed |
| adc_r | input | 16 | Right ADC sample, signed |
| dac_l | input | 16 | Left DAC input sample, signed |
| dac_r | input | 16 | Right DAC input sample, signed |
| mix_l | output | 16 | Left mixed sample, signed |
| mix_r | output | 16 | Right mixed sample, signed |
| mix_vld | output | 1 | Mixed samples valid strobe |

## Verification
Random codes with random full-scale samples cover all four mantissas and every shift. These show whether the mantissa index and the shift amount are taken from the correct bits of the code. Directed full-scale cases with the same sign, at code 0, push the sum past both rails to show the clamp, and a negative odd sample checks that rounding is toward minus infinity. The mute flag and code 63 are each tried alone on one side only, which separates the two silencing paths and the left field from the right. A write placed on the same cycle as the strobe shows which sample the new setting first reaches.

// File: rtl/stereo_mix_pkg.sv
// Shared constants and helpers for the stereo mix attenuator.
// Assumes a 16-bit control word with two 8-bit channel fields.
package stereo_mix_pkg;
    localparam int SMP_W   = 16;
    localparam int CODE_W  = 6;
    localparam int MANT_W  = 18;
    localparam int FRAC_W  = 15;
    localparam int CFG_W   = 16;
    localparam logic [CFG_W-1:0] CFG_DEFAULT = 16'h8080;
    localparam logic [CFG_W-1:0] CFG_KEEP    = 16'hBFBF;
    localparam logic [CODE_W-1:0] CODE_SILENT = '1;

    // Q1.15 gain for the fine (sub-6 dB) part of an attenuation code.
    function automatic logic signed [MANT_W-1:0] fine_gain(input logic [1:0] sel);
        case (sel)
            2'd0:    fine_gain = 18'sd32768;
            2'd1:    fine_gain = 18'sd27554;
            2'd2:    fine_gain = 18'sd23170;
            default: fine_gain = 18'sd19484;
        endcase
    endfunction
endpackage

// File: rtl/mix_cfg_reg.sv
// Control word holding both channel fields.
// Snaps to default and ignores writes while reset, power-down or
// conversion-disable is active. Reserved bits are forced to zero.
module mix_cfg_reg
    import stereo_mix_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_n,
    input  logic             conv_off,
    input  logic             we,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] q
);
    logic lock;
    assign lock = !rst_n || !pwr_n || conv_off;

    // Hold default while locked, otherwise accept masked writes.
    always_ff @(posedge clk) begin
        if (lock)    q <= CFG_DEFAULT;
        else if (we) q <= wdata & CFG_KEEP;
    end

    p_lockout_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_n || conv_off) |=> (q == CFG_DEFAULT));
    p_rsvd_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (q[14] == 1'b0) && (q[6] == 1'b0));
    p_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && pwr_n && !conv_off) |=> (q == ($past(wdata) & CFG_KEEP)));
endmodule

// File: rtl/mix_gain_lane.sv
// One channel: scales the ADC sample by the coded gain and adds it
// to the DAC sample with saturation. Purely combinational.
// Assumes code 63 or mute removes the ADC term entirely.
module mix_gain_lane
    import stereo_mix_pkg::*;
(
    input  logic                     mute,
    input  logic [CODE_W-1:0]        code,
    input  logic signed [SMP_W-1:0]  adc,
    input  logic signed [SMP_W-1:0]  dac,
    output logic signed [SMP_W-1:0]  mixed
);
    localparam int PROD_W = SMP_W + MANT_W;
    localparam int SUM_W  = SMP_W + 2;
    localparam logic signed [SUM_W-1:0] MAX_V = SUM_W'(2**(SMP_W-1) - 1);
    localparam logic signed [SUM_W-1:0] MIN_V = -SUM_W'(2**(SMP_W-1));

    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] shifted;
    logic [4:0]               shamt;
    logic signed [SUM_W-1:0]  term;
    logic signed [SUM_W-1:0]  sum;

    // Product of sample and fine gain, then coarse 6 dB shifts.
    always_comb begin
        prod    = PROD_W'(adc) * PROD_W'(fine_gain(code[1:0]));
        shamt   = 5'(FRAC_W) + {1'b0, code[CODE_W-1:2]};
        shifted = prod >>> shamt;
        term    = (mute || code == CODE_SILENT) ? '0 : shifted[SUM_W-1:0];
    end

    // Add and clamp to the signed sample range.
    always_comb begin
        sum = SUM_W'(dac) + term;
        if (sum > MAX_V)      mixed = MAX_V[SMP_W-1:0];
        else if (sum < MIN_V) mixed = MIN_V[SMP_W-1:0];
        else                  mixed = sum[SMP_W-1:0];
    end
endmodule

// File: rtl/stereo_mix_atten.sv
// Stereo ADC-to-DAC digital mix with per-channel mute and
// 1.5 dB-step attenuation. Outputs register one clock after the
// shared sample strobe. Assumes ADC and DAC share that strobe.
module stereo_mix_atten
    import stereo_mix_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_n,
    input  logic              conv_off,
    input  logic              cfg_we,
    input  logic [15:0]       cfg_wdata,
    output logic [15:0]       cfg_rdata,
    input  logic              smp_vld,
    input  logic signed [15:0] adc_l,
    input  logic signed [15:0] adc_r,
    input  logic signed [15:0] dac_l,
    input  logic signed [15:0] dac_r,
    output logic signed [15:0] mix_l,
    output logic signed [15:0] mix_r,
    output logic              mix_vld
);
    localparam int NCH    = 2;
    localparam int FIELD_W = CFG_W / NCH;

    logic [CFG_W-1:0]        cfg_q;
    logic signed [SMP_W-1:0] adc_a [NCH];
    logic signed [SMP_W-1:0] dac_a [NCH];
    logic signed [SMP_W-1:0] lane_o [NCH];

    assign adc_a[0] = adc_l;
    assign adc_a[1] = adc_r;
    assign dac_a[0] = dac_l;
    assign dac_a[1] = dac_r;
    assign cfg_rdata = cfg_q;

    mix_cfg_reg u_cfg (
        .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .conv_off(conv_off),
        .we(cfg_we), .wdata(cfg_wdata), .q(cfg_q)
    );

    // Channel 0 (left) uses the upper field, channel 1 (right) the lower.
    for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
        localparam int BASE = (NCH - 1 - ch) * FIELD_W;
        mix_gain_lane u_lane (
            .mute (cfg_q[BASE + FIELD_W - 1]),
            .code (cfg_q[BASE + CODE_W - 1 : BASE]),
            .adc  (adc_a[ch]),
            .dac  (dac_a[ch]),
            .mixed(lane_o[ch])
        );
    end

    // Capture mixed samples on the strobe and flag them valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mix_l   <= '0;
            mix_r   <= '0;
            mix_vld <= 1'b0;
        end else begin
            mix_vld <= smp_vld;
            if (smp_vld) begin
                mix_l <= lane_o[0];
                mix_r <= lane_o[1];
            end
        end
    end

    p_vld_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        smp_vld |=> mix_vld);
    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld |=> (!mix_vld && $stable(mix_l) && $stable(mix_r)));
    p_mute_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && cfg_q[15]) |=> (mix_l == $past(dac_l)));
    p_silent_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld && cfg_q[5:0] == CODE_SILENT) |=> (mix_r == $past(dac_r)));
endmodule

// File: tb/stereo_mix_atten_bench.sv
module stereo_mix_atten_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0, pwr_n = 1'b1, conv_off = 1'b0, cfg_we = 1'b0, smp_vld = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic signed [15:0] adc_l = '0, adc_r = '0, dac_l = '0, dac_r = '0;
    logic signed [15:0] mix_l, mix_r;
    logic mix_vld;
    int n_chk = 0, n_fail = 0, cyc = 0;
    logic [15:0] model = 16'h8080;

    always #2 clk = ~clk;

    stereo_mix_atten u_stereo_mix_atten (
        .clk(clk), .rst_n(rst_n), .pwr_n(pwr_n), .conv_off(conv_off),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .smp_vld(smp_vld), .adc_l(adc_l), .adc_r(adc_r), .dac_l(dac_l), .dac_r(dac_r),
        .mix_l(mix_l), .mix_r(mix_r), .mix_vld(mix_vld)
    );

    function automatic int gain_of(input int c);
        case (c % 4)
            0: return 32768;
            1: return 27554;
            2: return 23170;
            default: return 19484;
        endcase
    endfunction

    function automatic int expect_mix(input int dac, input int adc, input bit mute, input int code);
        longint t, s;
        if (mute || code == 63) t = 0;
        else begin
            t = longint'(adc) * gain_of(code);
            t = t >>> (15 + code / 4);
        end
        s = dac + t;
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return int'(s);
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic write_cfg(input logic [15:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        model = v & 16'hBFBF;
    endtask

    // One strobe; checks both channels one cycle later against model.
    task automatic sample(input int al, input int ar, input int dl, input int dr, input string req);
        int el, er;
        @(negedge clk);
        smp_vld = 1'b1;
        adc_l = 16'(al); adc_r = 16'(ar); dac_l = 16'(dl); dac_r = 16'(dr);
        el = expect_mix(dl, al, model[15], int'(model[13:8]));
        er = expect_mix(dr, ar, model[7], int'(model[5:0]));
        @(negedge clk);
        smp_vld = 1'b0;
        check({req, " left"}, int'(mix_l), el);
        check({req, " right"}, int'(mix_r), er);
        check("R9 valid", int'(mix_vld), 1);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 100000) begin
                n_chk++; n_fail++;
                $display("FAIL watchdog actual=%0d expected=<100000", cyc);
                finish_run();
            end
        end
    end

    initial begin
        int mute_sel;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 cfg default", int'(cfg_rdata), 32'h8080);
        check("R1 vld low", int'(mix_vld), 0);
        check("R1 mix_l zero", int'(mix_l), 0);
        // R5: default is muted, output equals dac
        sample(1000, -1000, 123, -456, "R5 default muted");
        // R2/R3: write layout, reserved masked
        write_cfg(16'hFFFF);
        check("R3 reserved zero", int'(cfg_rdata), 32'hBFBF);
        write_cfg(16'h0A15);
        check("R2 fields stored", int'(cfg_rdata), 32'h0A15);
        // R7: gain path, negative odd sample
        write_cfg(16'h0105);
        sample(-12345, 7777, 10, -20, "R7 gain");
        // R8: saturation both rails
        write_cfg(16'h0000);
        sample(30000, -30000, 30000, -30000, "R8 clamp");
        check("R8 high rail", int'(mix_l), 32767);
        check("R8 low rail", int'(mix_r), -32768);
        // R6: code 63 with mute 0 on right only; R5 mute on left only
        write_cfg(16'h003F);
        sample(5000, 5000, 100, 200, "R6 silent code");
        check("R6 right passthrough", int'(mix_r), 200);
        write_cfg(16'h8000);
        sample(5000, 5000, 100, 200, "R5 left mute");
        check("R5 left passthrough", int'(mix_l), 100);
        // R9: outputs hold without strobe
        @(negedge clk); adc_l = 16'sd999; dac_l = 16'sd999;
        @(negedge clk);
        check("R9 no strobe vld", int'(mix_vld), 0);
        check("R9 hold", int'(mix_l), 100);
        // R10: write coincident with strobe
        @(negedge clk);
        smp_vld = 1'b1; cfg_we = 1'b1; cfg_wdata = 16'h8080;
        adc_l = 16'sd4000; adc_r = 16'sd4000; dac_l = 16'sd1; dac_r = 16'sd2;
        @(negedge clk);
        smp_vld = 1'b0; cfg_we = 1'b0;
        check("R10 old setting left", int'(mix_l), expect_mix(1, 4000, 1'b1, 0));
        check("R10 old setting right", int'(mix_r), expect_mix(2, 4000, 1'b0, 0));
        model = 16'h8080;
        sample(4000, 4000, 1, 2, "R10 new setting");
        // R4: power-down lockout with write
        write_cfg(16'h1111);
        @(negedge clk); pwr_n = 1'b0; cfg_we = 1'b1; cfg_wdata = 16'h2222;
        @(negedge clk); cfg_we = 1'b0;
        check("R4 pwr default", int'(cfg_rdata), 32'h8080);
        pwr_n = 1'b1;
        @(negedge clk); conv_off = 1'b1;
        @(negedge clk); cfg_we = 1'b1; cfg_wdata = 16'h3333;
        @(negedge clk); cfg_we = 1'b0;
        check("R4 conv_off ignores write", int'(cfg_rdata), 32'h8080);
        conv_off = 1'b0;
        model = 16'h8080;
        write_cfg(16'h0303);
        check("R4 writable after release", int'(cfg_rdata), 32'h0303);
        // R7: random codes and samples
        for (int i = 0; i < 300; i++) begin
            mute_sel = $urandom_range(0, 7);
            write_cfg({mute_sel == 0, 1'b0, 6'($urandom_range(0, 63)),
                       mute_sel == 1, 1'b0, 6'($urandom_range(0, 63))});
            sample($signed(16'($urandom)), $signed(16'($urandom)),
                   $signed(16'($urandom)), $signed(16'($urandom)), "R7 random");
        end
        // R1: reset mid-run
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 reset again", int'(cfg_rdata), 32'h8080);
        check("R1 mix cleared", int'(mix_r), 0);
        finish_run();
    end
endmodule